// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block is the synchronous control core of a byte-wide parallel NOR flash. Every bus write reaches it as a one-cycle strobe that carries an address and a data byte. A tracker follows the multi-write unlock handshakes. When a handshake completes, the block starts a byte program, a sector erase or a whole-array erase on a small internal byte array. The same tracker switches a product-identification view on and off. Reads are combinational from the address bus. They return either the array contents or the identification bytes.

Once an operation has started, the block reports itself busy for a fixed number of clock cycles, set per operation type by a parameter. It also exports a two-bit code for the running operation. While busy, it accepts no write of any kind. Erase does not finish in one cycle: a pointer walks through the target range and writes FFh to one byte per cycle. The busy window must therefore be at least as long as the range, and elaboration rejects any parameter set that breaks this. Sector size and array size are parameters, and the defaults are reduced so that simulation stays short.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: Three writes AAh@5555h, 55h@2AAAh and A0h@5555h, followed by a fourth write of any address and byte, start a program. The program sets busy_o for exactly PROG_CYC cycles with op_o = 1, and it alters the byte at that address.
- R2: The writes AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, followed by 30h at any address, erase to FFh every byte of the sector holding that address. A sector is a block of 2^SEC_AW bytes chosen by address bits ARR_AW-1 down to SEC_AW. No other byte changes. busy_o stays high for SECT_CYC cycles with op_o = 2.
- R3: The same five writes followed by 10h@5555h set every array byte to FFh, with busy_o high for CHIP_CYC cycles and op_o = 3.
- R4: Command-cycle addresses are compared on bits 14:0 only. Set bits above bit 14 do not change how a command is recognised.
- R5: The writes AAh@5555h, 55h@2AAAh, 90h@5555h turn on the ID view. In this view a read at address 0 gives BFh, a read at address 1 gives DEV_CODE, and a read at any other address gives 00h.
- R6: The ID view is turned off by one F0h write to any address, or by AAh@5555h, 55h@2AAAh, F0h@5555h. After that, reads return array data again.
- R7: A write that is not the next expected step of a sequence cancels the sequence and turns off the ID view. Later writes then start over from the first step.
- R8: While busy_o is high, every write is ignored. Such a write starts no operation, does not change the ID view, and leaves no partial sequence behind.
- R9: A program stores the bitwise AND of the old byte and the written byte. Writing FFh leaves the byte unchanged.
- R10: After reset, busy_o is 0, op_o is 0 and the ID view is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | One-cycle write strobe |
| addr_i | input | ADDR_W | Byte address for writes and reads |
| wdata_i | input | 8 | Write data byte |
| rdata_o | output | 8 | Read data for addr_i (array or ID byte) |
| busy_o | output | 1 | High while an internal operation runs |
| op_o | output | 2 | Running operation: 0 none, 1 program, 2 sector erase, 3 chip erase |

## Verification
The assertions assume that wr_i is a clean single-cycle pulse, and that addr_i and wdata_i hold steady around each clock edge. The bench drives all inputs on the falling edge, raises wr_i for exactly one cycle per write, and keeps reads and writes apart. The assertions also assume that the array has been erased before its contents are checked. For that reason the bench starts with a whole-array erase, before any byte is read as data.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

   typedef enum logic [2:0] {
      SQ_IDLE = 3'd0,
      SQ_UNL1 = 3'd1,
      SQ_UNL2 = 3'd2,
      SQ_PROG = 3'd3,
      SQ_ERS1 = 3'd4,
      SQ_ERS2 = 3'd5,
      SQ_ERS3 = 3'd6
   } seq_e;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_PROG = 2'd1,
      OP_SECT = 2'd2,
      OP_CHIP = 2'd3
   } op_e;

   localparam logic [14:0] CMD_ADR_A = 15'h5555;
   localparam logic [14:0] CMD_ADR_B = 15'h2AAA;

   localparam logic [7:0] K_KEY1  = 8'hAA;
   localparam logic [7:0] K_KEY2  = 8'h55;
   localparam logic [7:0] K_PROG  = 8'hA0;
   localparam logic [7:0] K_ERASE = 8'h80;
   localparam logic [7:0] K_SECT  = 8'h30;
   localparam logic [7:0] K_CHIP  = 8'h10;
   localparam logic [7:0] K_IDON  = 8'h90;
   localparam logic [7:0] K_IDOFF = 8'hF0;
   localparam logic [7:0] MFR_ID  = 8'hBF;

endpackage

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
   import nor_cmd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_i,
   input  logic [14:0] cadr_i,
   input  logic [7:0]  wdata_i,
   input  logic        busy_i,
   output seq_e        state_o,
   output logic        id_o,
   output logic        launch_o,
   output op_e         lop_o
);

   seq_e st_q, st_n;
   logic id_q, id_n;
   logic at_a, at_b;

   assign at_a = (cadr_i == CMD_ADR_A);
   assign at_b = (cadr_i == CMD_ADR_B);

   always_comb begin
      st_n     = st_q;
      id_n     = id_q;
      launch_o = 1'b0;
      lop_o    = OP_NONE;
      if (wr_i && !busy_i) begin
         st_n = SQ_IDLE;
         unique case (st_q)
            SQ_IDLE, SQ_ERS1: begin
               if (at_a && wdata_i == K_KEY1) st_n = (st_q == SQ_IDLE) ? SQ_UNL1 : SQ_ERS2;
               else                           id_n = 1'b0;
            end
            SQ_UNL1, SQ_ERS2: begin
               if (at_b && wdata_i == K_KEY2) st_n = (st_q == SQ_UNL1) ? SQ_UNL2 : SQ_ERS3;
               else                           id_n = 1'b0;
            end
            SQ_UNL2: begin
               if      (at_a && wdata_i == K_PROG)  st_n = SQ_PROG;
               else if (at_a && wdata_i == K_ERASE) st_n = SQ_ERS1;
               else if (at_a && wdata_i == K_IDON)  id_n = 1'b1;
               else                                 id_n = 1'b0;
            end
            SQ_PROG: begin
               launch_o = 1'b1;
               lop_o    = OP_PROG;
            end
            SQ_ERS3: begin
               if (wdata_i == K_SECT) begin
                  launch_o = 1'b1;
                  lop_o    = OP_SECT;
               end else if (at_a && wdata_i == K_CHIP) begin
                  launch_o = 1'b1;
                  lop_o    = OP_CHIP;
               end else begin
                  id_n = 1'b0;
               end
            end
            default: id_n = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= SQ_IDLE;
         id_q <= 1'b0;
      end else begin
         st_q <= st_n;
         id_q <= id_n;
      end
   end

   assign state_o = st_q;
   assign id_o    = id_q;

endmodule

// File: rtl/nor_op_timer.sv
module nor_op_timer
   import nor_cmd_pkg::*;
#(
   parameter int ARR_AW   = 11,
   parameter int SEC_AW   = 9,
   parameter int PROG_CYC = 16,
   parameter int SECT_CYC = 600,
   parameter int CHIP_CYC = 2100
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     launch_i,
   input  op_e                      lop_i,
   input  logic [ARR_AW-SEC_AW-1:0] sect_i,
   output logic                     busy_o,
   output op_e                      op_o,
   output logic                     ers_we_o,
   output logic [ARR_AW-1:0]        ers_addr_o
);

   localparam int MAXC = (CHIP_CYC > SECT_CYC)
                       ? ((CHIP_CYC > PROG_CYC) ? CHIP_CYC : PROG_CYC)
                       : ((SECT_CYC > PROG_CYC) ? SECT_CYC : PROG_CYC);
   localparam int CW   = $clog2(MAXC + 1);
   localparam int RW   = ARR_AW + 1;
   localparam logic [CW-1:0] P_LAST = CW'(PROG_CYC - 1);
   localparam logic [CW-1:0] S_LAST = CW'(SECT_CYC - 1);
   localparam logic [CW-1:0] C_LAST = CW'(CHIP_CYC - 1);
   localparam logic [RW-1:0] S_BYTES = RW'(1) << SEC_AW;
   localparam logic [RW-1:0] C_BYTES = RW'(1) << ARR_AW;

   logic              busy_q;
   op_e               op_q;
   logic [CW-1:0]     cnt_q;
   logic [RW-1:0]     rem_q;
   logic [ARR_AW-1:0] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         op_q   <= OP_NONE;
         cnt_q  <= '0;
         rem_q  <= '0;
         ptr_q  <= '0;
      end else if (launch_i) begin
         busy_q <= 1'b1;
         op_q   <= lop_i;
         unique case (lop_i)
            OP_SECT: begin
               cnt_q <= S_LAST;
               rem_q <= S_BYTES;
               ptr_q <= {sect_i, {SEC_AW{1'b0}}};
            end
            OP_CHIP: begin
               cnt_q <= C_LAST;
               rem_q <= C_BYTES;
               ptr_q <= '0;
            end
            default: begin
               cnt_q <= P_LAST;
               rem_q <= '0;
               ptr_q <= '0;
            end
         endcase
      end else if (busy_q) begin
         if (cnt_q == '0) begin
            busy_q <= 1'b0;
            op_q   <= OP_NONE;
         end else begin
            cnt_q <= cnt_q - 1'b1;
         end
         if (rem_q != '0) begin
            rem_q <= rem_q - 1'b1;
            ptr_q <= ptr_q + 1'b1;
         end
      end
   end

   assign busy_o     = busy_q;
   assign op_o       = op_q;
   assign ers_we_o   = busy_q && (rem_q != '0);
   assign ers_addr_o = ptr_q;

endmodule

// File: rtl/nor_byte_array.sv
module nor_byte_array
   import nor_cmd_pkg::*;
#(
   parameter int          ADDR_W   = 17,
   parameter int          ARR_AW   = 11,
   parameter logic [7:0]  DEV_CODE = 8'h5A
) (
   input  logic              clk,
   input  logic              pg_we_i,
   input  logic [ARR_AW-1:0] pg_addr_i,
   input  logic [7:0]        pg_data_i,
   input  logic              er_we_i,
   input  logic [ARR_AW-1:0] er_addr_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   input  logic              id_i,
   output logic [7:0]        rdata_o
);

   localparam int DEPTH = 1 << ARR_AW;

   logic [7:0] mem [0:DEPTH-1];
   logic [7:0] id_byte;

   always_ff @(posedge clk) begin
      if (pg_we_i)      mem[pg_addr_i] <= mem[pg_addr_i] & pg_data_i;
      else if (er_we_i) mem[er_addr_i] <= 8'hFF;
   end

   always_comb begin
      if (rd_addr_i == '0)                 id_byte = MFR_ID;
      else if (rd_addr_i == ADDR_W'(1))    id_byte = DEV_CODE;
      else                                 id_byte = 8'h00;
   end

   assign rdata_o = id_i ? id_byte : mem[rd_addr_i[ARR_AW-1:0]];

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
   import nor_cmd_pkg::*;
#(
   parameter int          ADDR_W   = 17,
   parameter int          ARR_AW   = 11,
   parameter int          SEC_AW   = 9,
   parameter int          PROG_CYC = 16,
   parameter int          SECT_CYC = 600,
   parameter int          CHIP_CYC = 2100,
   parameter logic [7:0]  DEV_CODE = 8'h5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [7:0]        wdata_i,
   output logic [7:0]        rdata_o,
   output logic              busy_o,
   output logic [1:0]        op_o
);

   localparam int SEC_BYTES = 1 << SEC_AW;
   localparam int ARR_BYTES = 1 << ARR_AW;

   if (ADDR_W < 15) begin : g_bad_aw
      $error("ADDR_W must cover command address bits 14:0");
   end
   if (ARR_AW > ADDR_W || SEC_AW >= ARR_AW) begin : g_bad_geom
      $error("array or sector width out of range");
   end
   if (SECT_CYC < SEC_BYTES || CHIP_CYC < ARR_BYTES || PROG_CYC < 1) begin : g_bad_dur
      $error("erase time shorter than the byte walk");
   end

   seq_e seq_st;
   logic id_mode;
   logic launch;
   op_e  lop;
   op_e  run_op;
   logic busy;
   logic ers_we;
   logic [ARR_AW-1:0] ers_addr;

   nor_cmd_seq u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_i     (wr_i),
      .cadr_i   (addr_i[14:0]),
      .wdata_i  (wdata_i),
      .busy_i   (busy),
      .state_o  (seq_st),
      .id_o     (id_mode),
      .launch_o (launch),
      .lop_o    (lop)
   );

   nor_op_timer #(
      .ARR_AW   (ARR_AW),
      .SEC_AW   (SEC_AW),
      .PROG_CYC (PROG_CYC),
      .SECT_CYC (SECT_CYC),
      .CHIP_CYC (CHIP_CYC)
   ) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch_i   (launch),
      .lop_i      (lop),
      .sect_i     (addr_i[ARR_AW-1:SEC_AW]),
      .busy_o     (busy),
      .op_o       (run_op),
      .ers_we_o   (ers_we),
      .ers_addr_o (ers_addr)
   );

   nor_byte_array #(
      .ADDR_W   (ADDR_W),
      .ARR_AW   (ARR_AW),
      .DEV_CODE (DEV_CODE)
   ) u_arr (
      .clk       (clk),
      .pg_we_i   (launch && lop == OP_PROG),
      .pg_addr_i (addr_i[ARR_AW-1:0]),
      .pg_data_i (wdata_i),
      .er_we_i   (ers_we),
      .er_addr_i (ers_addr),
      .rd_addr_i (addr_i),
      .id_i      (id_mode),
      .rdata_o   (rdata_o)
   );

   assign busy_o = busy;
   assign op_o   = run_op;

endmodule

// File: rtl/nor_cmd_chk.sv
module nor_cmd_chk
   import nor_cmd_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        wr_i,
   input logic [14:0] cadr_i,
   input logic [7:0]  wdata_i,
   input logic        busy_i,
   input logic [1:0]  op_i,
   input logic [2:0]  st_i,
   input logic        id_i
);

   // R8: no sequence progress can exist during an operation
   a_r8_idle_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |-> st_i == SQ_IDLE);

   // R8: a write during an operation leaves the ID view as it was
   a_r8_busy_keeps_id: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_i && wr_i) |=> id_i == $past(id_i));

   // R1: the fourth program write starts a program
   a_r1_prog_start: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == SQ_PROG && wr_i && !busy_i) |=> (busy_i && op_i == OP_PROG));

   // R2: final 30h starts a sector erase
   a_r2_sect_start: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == SQ_ERS3 && wr_i && !busy_i && wdata_i == K_SECT) |=> (busy_i && op_i == OP_SECT));

   // R3: final 10h at the command address starts a chip erase
   a_r3_chip_start: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == SQ_ERS3 && wr_i && !busy_i && wdata_i == K_CHIP && cadr_i == CMD_ADR_A)
      |=> (busy_i && op_i == OP_CHIP));

   // R7: a wrong second write cancels the sequence and the ID view
   a_r7_abort: assert property (@(posedge clk) disable iff (!rst_n)
      (st_i == SQ_UNL1 && wr_i && !busy_i && !(cadr_i == CMD_ADR_B && wdata_i == K_KEY2))
      |=> (st_i == SQ_IDLE && !id_i));

   // R10: the operation code is non-zero exactly while busy
   a_r10_op_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i == (op_i != 2'd0));

endmodule

bind nor_cmd_ctrl nor_cmd_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .wr_i    (wr_i),
   .cadr_i  (addr_i[14:0]),
   .wdata_i (wdata_i),
   .busy_i  (busy_o),
   .op_i    (op_o),
   .st_i    (seq_st),
   .id_i    (id_mode)
);

// File: tb/sim_nor_cmd_ctrl.sv
module sim_nor_cmd_ctrl;

   localparam int AW = 17;
   localparam int RA = 9;
   localparam int SA = 7;
   localparam int PC = 5;
   localparam int SC = 140;
   localparam int CC = 520;
   localparam logic [7:0] DEV = 8'hB7;
   localparam int NB = 1 << RA;
   localparam int SB = 1 << SA;
   localparam logic [AW-1:0] HI = AW'(3) << 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [7:0]    wdata = '0;
   wire  [7:0]    rdata;
   wire           busy;
   wire  [1:0]    op;

   int n_chk = 0;
   int n_fail = 0;
   logic [7:0] model [0:NB-1];

   always #2 clk = ~clk;

   nor_cmd_ctrl #(
      .ADDR_W(AW), .ARR_AW(RA), .SEC_AW(SA),
      .PROG_CYC(PC), .SECT_CYC(SC), .CHIP_CYC(CC), .DEV_CODE(DEV)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
      .rdata_o(rdata), .busy_o(busy), .op_o(op)
   );

   function automatic logic [7:0] pat(int a);
      return 8'((a * 37 + 11) & 255);
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr1(logic [AW-1:0] a, logic [7:0] d);
      @(negedge clk);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic cmd3(logic [7:0] d, logic [AW-1:0] hi);
      wr1(hi | AW'(17'h5555), 8'hAA);
      wr1(hi | AW'(17'h2AAA), 8'h55);
      wr1(hi | AW'(17'h5555), d);
   endtask

   task automatic erase6(logic [AW-1:0] a, logic [7:0] d, logic [AW-1:0] hi);
      cmd3(8'h80, hi);
      wr1(hi | AW'(17'h5555), 8'hAA);
      wr1(hi | AW'(17'h2AAA), 8'h55);
      wr1(a, d);
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic rd(logic [AW-1:0] a, output logic [7:0] v);
      @(negedge clk);
      addr = a;
      #1 v = rdata;
   endtask

   task automatic verify(string tag);
      logic [7:0] v;
      for (int a = 0; a < NB; a++) begin
         rd(AW'(a), v);
         chk(tag, v, model[a]);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      int n;
      logic [7:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 busy after reset", busy, 0);
      chk("R10 op after reset", op, 0);

      // whole-array erase
      erase6(AW'(17'h5555), 8'h10, '0);
      chk("R3 op code", op, 3);
      wait_idle(n);
      chk("R3 busy cycles", n, CC);
      for (int a = 0; a < NB; a++) model[a] = 8'hFF;
      verify("R3 array FF");
      rd('0, v);
      chk("R10 ID view off", v, 8'hFF);

      // program sweep, odd steps with upper address bits set
      for (int a = 0; a < NB; a++) begin
         cmd3(8'hA0, a[0] ? HI : '0);
         wr1(AW'(a), pat(a));
         if (a == 0) begin
            chk("R1 op code", op, 1);
            wait_idle(n);
            chk("R1 busy cycles", n, PC);
         end else begin
            wait_idle(n);
         end
         model[a] = pat(a);
      end
      verify("R1 R4 programmed bytes");

      // program clears bits only
      cmd3(8'hA0, '0); wr1(AW'(5), 8'h0F); wait_idle(n);
      model[5] = model[5] & 8'h0F;
      cmd3(8'hA0, '0); wr1(AW'(6), 8'hFF); wait_idle(n);
      rd(AW'(5), v); chk("R9 AND result", v, model[5]);
      rd(AW'(6), v); chk("R9 FF keeps byte", v, model[6]);

      // sector erase through an address inside sector 2, upper bits set
      erase6(HI | AW'(2 * SB + 35), 8'h30, HI);
      chk("R2 op code", op, 2);
      wait_idle(n);
      chk("R2 busy cycles", n, SC);
      for (int a = 2 * SB; a < 3 * SB; a++) model[a] = 8'hFF;
      verify("R2 sector only");

      // ID view and both exits
      cmd3(8'h90, '0);
      rd('0, v);        chk("R5 maker code", v, 8'hBF);
      rd(AW'(1), v);    chk("R5 device code", v, DEV);
      rd(AW'(2), v);    chk("R5 other address", v, 8'h00);
      wr1(AW'(17'h1234), 8'hF0);
      rd('0, v);        chk("R6 single-write exit", v, model[0]);
      cmd3(8'h90, HI);
      rd(AW'(1), v);    chk("R5 re-entry", v, DEV);
      cmd3(8'hF0, '0);
      rd(AW'(1), v);    chk("R6 three-write exit", v, model[1]);

      // aborts
      cmd3(8'h90, '0);
      wr1(AW'(17'h5555), 8'hAA);
      wr1(AW'(17'h2AAA), 8'h00);
      rd('0, v);        chk("R7 abort leaves ID view", v, model[0]);
      wr1(AW'(17'h5555), 8'hAA);
      wr1(AW'(17'h2AAA), 8'h55);
      wr1(AW'(17'h2AAA), 8'hA0);
      wr1(AW'(17'h5555), 8'hA0);
      wr1(AW'(300), 8'h00);
      chk("R7 no program after abort", busy, 0);
      rd(AW'(300), v);  chk("R7 byte kept", v, model[300]);
      cmd3(8'h80, '0);
      wr1(AW'(17'h5555), 8'hAA);
      wr1(AW'(17'h5555), 8'h55);
      wr1(AW'(40), 8'h30);
      chk("R7 no erase after abort", busy, 0);
      rd(AW'(40), v);   chk("R7 sector kept", v, model[40]);
      cmd3(8'hA0, '0); wr1(AW'(41), 8'h00); wait_idle(n);
      model[41] = 8'h00;
      rd(AW'(41), v);   chk("R7 restart works", v, 8'h00);

      // lockout while busy
      erase6(AW'(3), 8'h30, '0);
      cmd3(8'hA0, '0);
      wr1(AW'(SB + 2), 8'h00);
      cmd3(8'h90, '0);
      wait_idle(n);
      for (int a = 0; a < SB; a++) model[a] = 8'hFF;
      rd(AW'(SB + 2), v); chk("R8 program ignored", v, model[SB + 2]);
      rd('0, v);          chk("R8 ID entry ignored", v, 8'hFF);
      verify("R8 array after lockout");

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule